// File: doc/BRIEF.md
# Processor Interrupt and Reset Input Conditioner

This block sits between the asynchronous control pins of a processor core and the core's sequencer. It brings the maskable interrupt request, the non-maskable request, the external reset request and the wait-for-test input into the core clock domain through multi-stage synchronizers. From the synchronized values it builds three things:

- A filtered internal reset that is accepted only after a minimum run of high samples.
- A latched rising-edge detector for the non-maskable request.
- A fixed-priority decision that tells the core, in the last clock of each instruction, whether to take an interrupt and of which kind.

The core supplies an instruction-end strobe, its interrupt-enable flag and a flag showing that a wait-for-test instruction is executing. The block answers with a take-interrupt strobe, a non-maskable marker with its vector type, the internal reset and a hold indication for the test wait. The acknowledge bus cycles, the vector fetch and instruction execution stay in the core.

Top module: `irq_reset_conditioner`

## Requirements
- R1: `take_int_o` is high only in a cycle where `insn_end_i` is high and `core_rst_o` is low. Both outputs are combinational from that cycle's `insn_end_i` and the registered state.
- R2: The maskable request is level-sensitive. At a boundary it is taken only if its synchronized level is high and `if_flag_i` is 1 in that cycle. With the flag at 0 it has no effect. A request that drops before the boundary is not remembered.
- R3: A low-to-high transition on `nmi_req_i` is latched. The latched request is taken at the next boundary whatever the value of `if_flag_i`, and even if the pin has already returned low.
- R4: A non-maskable grant drives `take_int_o`=1, `take_nmi_o`=1 and `int_type_o`=2. A maskable grant drives `take_int_o`=1, `take_nmi_o`=0 and `int_type_o`=0.
- R5: When a latched non-maskable request and an enabled maskable request meet at the same boundary, the non-maskable one wins. Its latch clears when it is granted, so a single edge is serviced exactly once.
- R6: Holding `nmi_req_i` high produces no further service after the first one. Only a new low-to-high transition latches again.
- R7: `core_rst_o` rises only after the synchronized reset request has been high on 4 consecutive clocks (`RST_MIN_CYCLES`). A pulse that gives fewer high samples is ignored.
- R8: `core_rst_o` is 1 while `rst_n` is asserted. It falls on the first clock at which the synchronized reset request is low. While it is high, no interrupt is taken.
- R9: While `core_rst_o` is high, any latched non-maskable request is cleared and new edges are not latched.
- R10: `test_hold_o` is high exactly when `wait_test_i` is 1 and the synchronized `test_i` is 1.
- R11: Each asynchronous input passes through 2 flops (`SYNC_STAGES`). A change on `irq_req_i` or `test_i` appears at the outputs after 2 rising clock edges. An edge on `nmi_req_i` is latched after 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset for the block |
| irq_req_i | input | 1 | Asynchronous maskable interrupt request, level, active high |
| nmi_req_i | input | 1 | Asynchronous non-maskable request, rising-edge triggered |
| rst_req_i | input | 1 | Asynchronous external reset request, active high |
| test_i | input | 1 | Asynchronous wait-for-test input, high means keep waiting |
| insn_end_i | input | 1 | From core: current cycle is the last clock of an instruction |
| if_flag_i | input | 1 | From core: interrupt-enable flag |
| wait_test_i | input | 1 | From core: a wait-for-test instruction is executing |
| take_int_o | output | 1 | Enter interrupt service at this boundary |
| take_nmi_o | output | 1 | The granted interrupt is the non-maskable one |
| int_type_o | output | TYPE_W | Vector type of a non-maskable grant (2), else 0 |
| core_rst_o | output | 1 | Filtered internal reset for the core |
| test_hold_o | output | 1 | Keep the core idle in its wait-for-test instruction |

## Verification
On every cycle, the assertions check the following:

- Grants occur only at boundaries and never under internal reset.
- A maskable grant always has the flag set.
- A latched non-maskable request always wins its boundary.
- The internal reset clears the latch.
- The internal reset rises only after four consecutive high synchronized samples.
- It falls once those samples go low.

Only the bench scenarios can show the following:

- The exact synchronizer latencies.
- That a request dropped before the boundary is forgotten, while an edge survives the pin falling.
- That a held pin yields one service.
- That a short reset pulse leaves a pending request intact.

The bench also sweeps every combination of request level, flag, boundary and pending latch.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned IN_MASK  = 0;
  localparam int unsigned IN_NMI   = 1;
  localparam int unsigned IN_RST   = 2;
  localparam int unsigned IN_TEST  = 3;
  localparam int unsigned IN_COUNT = 4;

  typedef enum logic [1:0] {
    GRANT_NONE = 2'd0,
    GRANT_MASK = 2'd1,
    GRANT_NMI  = 2'd2
  } grant_e;
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] d;
    logic [WIDTH-1:0] q;
    if (s == 0) begin : g_first
      assign d = async_i;
    end else begin : g_next
      assign d = g_stage[s-1].q;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
    end
  end

  assign sync_o = g_stage[STAGES-1].q;
endmodule

// File: rtl/irqc_rst_filter.sv
module irqc_rst_filter #(
  parameter int unsigned MIN_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_sync_i,
  output logic core_rst_o
);
  localparam int unsigned CW = $clog2(MIN_CYCLES + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(MIN_CYCLES - 1);
  localparam logic [CW-1:0] CNT_SAT  = CW'(MIN_CYCLES);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          rst_q, rst_d;

  always_comb begin
    cnt_d = cnt_q;
    rst_d = rst_q;
    if (!req_sync_i) begin
      cnt_d = '0;
      rst_d = 1'b0;
    end else begin
      if (cnt_q == CNT_LAST) rst_d = 1'b1;
      if (cnt_q != CNT_SAT)  cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rst_q <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      rst_q <= rst_d;
    end
  end

  assign core_rst_o = rst_q;
endmodule

// File: rtl/irqc_nmi_latch.sv
module irqc_nmi_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_sync_i,
  input  logic core_rst_i,
  input  logic accept_i,
  output logic pend_o
);
  logic prev_q, prev_d;
  logic pend_q, pend_d;
  logic rise;

  assign rise = nmi_sync_i & ~prev_q;

  always_comb begin
    prev_d = nmi_sync_i;
    pend_d = pend_q;
    if (core_rst_i)    pend_d = 1'b0;
    else if (rise)     pend_d = 1'b1;
    else if (accept_i) pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= prev_d;
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter
  import irqc_pkg::*;
(
  input  logic   insn_end_i,
  input  logic   core_rst_i,
  input  logic   if_flag_i,
  input  logic   mreq_sync_i,
  input  logic   nmi_pend_i,
  output grant_e grant_o
);
  always_comb begin
    grant_o = GRANT_NONE;
    if (insn_end_i && !core_rst_i) begin
      if (nmi_pend_i)                     grant_o = GRANT_NMI;
      else if (mreq_sync_i && if_flag_i)  grant_o = GRANT_MASK;
    end
  end
endmodule

// File: rtl/irq_reset_conditioner.sv
module irq_reset_conditioner
  import irqc_pkg::*;
#(
  parameter int unsigned SYNC_STAGES    = 2,
  parameter int unsigned RST_MIN_CYCLES = 4,
  parameter int unsigned TYPE_W         = 8,
  parameter int unsigned NMI_TYPE       = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_req_i,
  input  logic              nmi_req_i,
  input  logic              rst_req_i,
  input  logic              test_i,
  input  logic              insn_end_i,
  input  logic              if_flag_i,
  input  logic              wait_test_i,
  output logic              take_int_o,
  output logic              take_nmi_o,
  output logic [TYPE_W-1:0] int_type_o,
  output logic              core_rst_o,
  output logic              test_hold_o
);
  logic [IN_COUNT-1:0] async_in;
  logic [IN_COUNT-1:0] sync_in;
  logic   mreq_sync, nmi_sync, rst_sync, test_sync;
  logic   nmi_pend;
  grant_e grant;

  always_comb begin
    async_in          = '0;
    async_in[IN_MASK] = irq_req_i;
    async_in[IN_NMI]  = nmi_req_i;
    async_in[IN_RST]  = rst_req_i;
    async_in[IN_TEST] = test_i;
  end

  irqc_sync #(.WIDTH(IN_COUNT), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (async_in),
    .sync_o  (sync_in)
  );

  assign mreq_sync = sync_in[IN_MASK];
  assign nmi_sync  = sync_in[IN_NMI];
  assign rst_sync  = sync_in[IN_RST];
  assign test_sync = sync_in[IN_TEST];

  irqc_rst_filter #(.MIN_CYCLES(RST_MIN_CYCLES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_sync_i (rst_sync),
    .core_rst_o (core_rst_o)
  );

  irqc_nmi_latch u_nmi (
    .clk        (clk),
    .rst_n      (rst_n),
    .nmi_sync_i (nmi_sync),
    .core_rst_i (core_rst_o),
    .accept_i   (take_nmi_o),
    .pend_o     (nmi_pend)
  );

  irqc_arbiter u_arb (
    .insn_end_i  (insn_end_i),
    .core_rst_i  (core_rst_o),
    .if_flag_i   (if_flag_i),
    .mreq_sync_i (mreq_sync),
    .nmi_pend_i  (nmi_pend),
    .grant_o     (grant)
  );

  assign take_int_o  = (grant != GRANT_NONE);
  assign take_nmi_o  = (grant == GRANT_NMI);
  assign int_type_o  = take_nmi_o ? TYPE_W'(NMI_TYPE) : '0;
  assign test_hold_o = wait_test_i & test_sync;
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker (
  input logic clk,
  input logic rst_n,
  input logic insn_end_i,
  input logic if_flag_i,
  input logic wait_test_i,
  input logic take_int_o,
  input logic take_nmi_o,
  input logic core_rst_o,
  input logic test_hold_o,
  input logic rst_sync,
  input logic nmi_pend
);
  AST_TAKE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    take_int_o |-> (insn_end_i && !core_rst_o)); // R1

  AST_MASK_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (take_int_o && !take_nmi_o) |-> if_flag_i); // R2

  AST_NMI_IS_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    take_nmi_o |-> take_int_o); // R4

  AST_NMI_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_end_i && nmi_pend && !core_rst_o) |-> take_nmi_o); // R5

  AST_RST_MIN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_rst_o) |-> ($past(rst_sync, 1) && $past(rst_sync, 2) &&
                           $past(rst_sync, 3) && $past(rst_sync, 4))); // R7

  AST_RST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_sync |=> !core_rst_o); // R8

  AST_RST_CLEARS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst_o |=> !nmi_pend); // R9

  AST_HOLD_NEEDS_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    test_hold_o |-> wait_test_i); // R10
endmodule

bind irq_reset_conditioner irqc_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .insn_end_i  (insn_end_i),
  .if_flag_i   (if_flag_i),
  .wait_test_i (wait_test_i),
  .take_int_o  (take_int_o),
  .take_nmi_o  (take_nmi_o),
  .core_rst_o  (core_rst_o),
  .test_hold_o (test_hold_o),
  .rst_sync    (rst_sync),
  .nmi_pend    (nmi_pend)
);

// File: tb/irq_reset_conditioner_test.sv
`timescale 1ns/1ps
module irq_reset_conditioner_test;
  logic clk = 1'b0;
  logic rst_n;
  logic irq_req_i, nmi_req_i, rst_req_i, test_i;
  logic insn_end_i, if_flag_i, wait_test_i;
  logic take_int_o, take_nmi_o, core_rst_o, test_hold_o;
  logic [7:0] int_type_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irq_reset_conditioner uut (
    .clk(clk), .rst_n(rst_n), .irq_req_i(irq_req_i), .nmi_req_i(nmi_req_i),
    .rst_req_i(rst_req_i), .test_i(test_i), .insn_end_i(insn_end_i),
    .if_flag_i(if_flag_i), .wait_test_i(wait_test_i), .take_int_o(take_int_o),
    .take_nmi_o(take_nmi_o), .int_type_o(int_type_o), .core_rst_o(core_rst_o),
    .test_hold_o(test_hold_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic settle();
    #1;
  endtask

  initial begin
    rst_n = 1'b0; irq_req_i = 0; nmi_req_i = 0; rst_req_i = 0; test_i = 0;
    insn_end_i = 0; if_flag_i = 0; wait_test_i = 0;
    cyc(3);
    rst_n = 1'b1;
    settle();
    chk("R8 reset state core_rst", int'(core_rst_o), 1);
    chk("R1 reset state take", int'(take_int_o), 0);
    chk("R10 reset state hold", int'(test_hold_o), 0);
    cyc(2); settle();
    chk("R8 core_rst released", int'(core_rst_o), 0);

    // R11: latency of the maskable request through two flops
    cyc(1);
    irq_req_i = 1; if_flag_i = 1; insn_end_i = 1; settle();
    chk("R11 latency 0 edges", int'(take_int_o), 0);
    cyc(1); settle();
    chk("R11 latency 1 edge", int'(take_int_o), 0);
    cyc(1); settle();
    chk("R11 latency 2 edges", int'(take_int_o), 1);
    cyc(1); insn_end_i = 0; irq_req_i = 0; cyc(3);

    // R1 R2 R3 R4 R5: sweep request level, flag, boundary and pending latch
    for (int c = 0; c < 16; c++) begin
      bit m, f, e, p;
      int exp_take, exp_nmi;
      m = c[0]; f = c[1]; e = c[2]; p = c[3];
      irq_req_i = m; if_flag_i = f; nmi_req_i = p; insn_end_i = 0;
      cyc(4);
      insn_end_i = e; settle();
      exp_nmi  = (e && p) ? 1 : 0;
      exp_take = (e && (p || (m && f))) ? 1 : 0;
      chk("R1 R2 sweep take_int", int'(take_int_o), exp_take);
      chk("R5 sweep take_nmi", int'(take_nmi_o), exp_nmi);
      chk("R4 sweep int_type", int'(int_type_o), exp_nmi ? 2 : 0);
      cyc(1);
      irq_req_i = 0; nmi_req_i = 0; insn_end_i = 0; if_flag_i = 0;
      cyc(3);
      if (p && !e) begin
        insn_end_i = 1; settle();
        chk("R3 pending served after pin drop, flag clear", int'(take_nmi_o), 1);
        cyc(1);
      end
      insn_end_i = 1; settle();
      chk("R5 latch cleared after grant", int'(take_int_o), 0);
      cyc(1); insn_end_i = 0; cyc(1);
    end

    // R2: a maskable request that drops before the boundary is forgotten
    irq_req_i = 1; if_flag_i = 1; cyc(3);
    irq_req_i = 0; cyc(3);
    insn_end_i = 1; settle();
    chk("R2 dropped level not remembered", int'(take_int_o), 0);
    cyc(1); insn_end_i = 0;

    // R6: held NMI gives one service only
    nmi_req_i = 1; cyc(4);
    insn_end_i = 1; settle();
    chk("R6 first service", int'(take_nmi_o), 1);
    cyc(1); settle();
    chk("R6 no second service while held", int'(take_nmi_o), 0);
    cyc(1); insn_end_i = 0; nmi_req_i = 0; cyc(3);

    // R7 R9: reset pulse length sweep with a pending NMI
    for (int len = 1; len <= 6; len++) begin
      bit seen;
      nmi_req_i = 1; cyc(4); nmi_req_i = 0; cyc(3);
      rst_req_i = 1; cyc(len); rst_req_i = 0;
      seen = 0;
      for (int k = 0; k < 10; k++) begin
        settle();
        if (core_rst_o) seen = 1;
        cyc(1);
      end
      chk("R7 reset accepted only for >=4 clocks", int'(seen), (len >= 4) ? 1 : 0);
      chk("R8 released after pulse", int'(core_rst_o), 0);
      insn_end_i = 1; settle();
      chk("R9 pending survives short pulse only", int'(take_nmi_o), (len >= 4) ? 0 : 1);
      cyc(1); insn_end_i = 0; cyc(1);
    end

    // R8: no grant while internal reset is active, resumes afterwards
    rst_req_i = 1; cyc(7);
    irq_req_i = 1; if_flag_i = 1; insn_end_i = 1; cyc(2); settle();
    chk("R8 core_rst held", int'(core_rst_o), 1);
    chk("R8 no take under reset", int'(take_int_o), 0);
    rst_req_i = 0; cyc(4); settle();
    chk("R8 core_rst dropped", int'(core_rst_o), 0);
    chk("R8 take resumes", int'(take_int_o), 1);
    cyc(1); insn_end_i = 0; irq_req_i = 0; if_flag_i = 0; cyc(3);

    // R10: test hold over all combinations
    for (int c = 0; c < 4; c++) begin
      test_i = c[0]; wait_test_i = 0; cyc(3);
      wait_test_i = c[1]; settle();
      chk("R10 test hold", int'(test_hold_o), (c[0] && c[1]) ? 1 : 0);
      cyc(1);
    end
    test_i = 1; wait_test_i = 1; cyc(3);
    test_i = 0; cyc(1); settle();
    chk("R11 test drop after 1 edge", int'(test_hold_o), 1);
    cyc(1); settle();
    chk("R11 test drop after 2 edges", int'(test_hold_o), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule